// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects a set of interrupt sources (sixteen by default) and presents one request level to the processor. Each source has an 8-bit control byte that sets its request level (1 to 7), its enable, level or edge sensing, and the active polarity. Reading the byte back also shows whether the source is currently asserting. Raw inputs are treated as asynchronous and pass through a two-flop synchroniser. In edge mode, a qualifying transition is latched as pending until software clears it.

Each cycle the controller takes the highest level among the enabled, asserting sources and registers it onto `cpu_ipl`. A master enable bit gates that output. When the processor raises `iack`, an acknowledge state machine moves from `ACK_IDLE` to `ACK_GRANT` if a request is presented. On that move it captures the vector: the programmable base plus the winner's source code. A tie at the winning level goes to the highest source code. With no request it moves to `ACK_SPUR` and reports no valid vector. Both states return to `ACK_IDLE` when `iack` drops.

The register address map is: `0`..`N_SRC-1` for the source control bytes, `N_SRC` for the general control byte (bit 0 is the master enable), and `N_SRC+1` for the vector base.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset every readable register reads 0, `cpu_ipl` is 0 and `vec_valid` is 0.
- R2: A source whose level field (control bits 2:0) is 0, or whose enable (bit 4) is clear, never contributes to `cpu_ipl`.
- R3: Reading a source control byte returns polarity (bit 7), mode (bit 6), the live active state (bit 5, whether or not the source is enabled), enable (bit 4), 0 in bit 3, and the level in bits 2:0.
- R4: In level mode (bit 6 = 0), the source is active while its synchronised input is high (bit 7 = 0) or low (bit 7 = 1), and inactive otherwise.
- R5: In edge mode (bit 6 = 1), a rising edge (bit 7 = 0) or falling edge (bit 7 = 1) of the input makes the source pending. It stays active after the input returns, and the opposite edge does not set it.
- R6: Writing a control byte with bit 3 set clears the pending state of an edge-mode source. In level mode the bit has no effect on the active state.
- R7: `cpu_ipl` equals the highest level among enabled active sources, updated within four clocks of an input change.
- R8: With the master enable (general control bit 0) clear, `cpu_ipl` is 0 and an acknowledge yields no valid vector.
- R9: On acknowledge, the vector is the base plus the winning source index. Among sources at the winning level, the highest index wins.
- R10: The vector is captured on the first cycle of `iack`. It stays valid and unchanged while `iack` is held, even if requests change, and `vec_valid` falls one clock after `iack` falls.
- R11: An acknowledge with no pending request leaves `vec_valid` at 0.
- R12: The vector sum wraps modulo 2^VEC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Raw asynchronous source inputs |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Write address |
| cfg_wdata | input | 8 | Write data |
| cfg_raddr | input | ADDR_W | Read address |
| cfg_rdata | output | 8 | Read data (combinational) |
| iack | input | 1 | Acknowledge strobe from the processor, held for the whole acknowledge |
| cpu_ipl | output | 3 | Registered request level toward the processor |
| vec_valid | output | 1 | High in ACK_GRANT |
| vec_out | output | VEC_W | Captured vector, 0 when not valid |

## Verification
The bench drives a seeded random mix of configuration writes, input toggles, master-enable flips and acknowledges. It holds a model of each source's pending state, so edge sources with both polarities are checked against level sources. Writes that flip the mode or polarity while the input is steady must create no pending edge. Directed cases cover the following, each isolating one rule:
- two sources tied at one level with different codes, which isolates the tie-break;
- a base near the top of the range, which separates a wrapping add from a saturating one;
- a request raised mid-acknowledge, which shows whether the vector was captured or tracked live;
- an acknowledge with nothing pending, and the master enable cleared;
- a clear-bit write on a level source.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int CTRL_W   = 8;
    localparam int LVL_W    = 3;
    localparam int BIT_CLR  = 3;
    localparam int BIT_EN   = 4;
    localparam int BIT_ACT  = 5;
    localparam int BIT_MODE = 6;
    localparam int BIT_POL  = 7;

    typedef struct packed {
        logic             pol;        // 1: falling edge / low level
        logic             edge_mode;  // 1: edge sensing
        logic             en;
        logic [LVL_W-1:0] lvl;
    } src_cfg_t;

    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_GRANT = 2'd1,
        ACK_SPUR  = 2'd2
    } ack_state_e;

endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond
    import intc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_in,
    input  logic              wr_sel,
    input  logic [CTRL_W-1:0] wdata,
    output src_cfg_t          cfg_o,
    output logic              active_o
);

    src_cfg_t               cfg_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pend_q;
    logic                   sync_s;
    logic                   edge_hit;
    logic                   clr_hit;
    logic                   unused_wbit;

    assign unused_wbit = wdata[BIT_ACT];
    assign sync_s      = sync_q[SYNC_STAGES-1];
    assign edge_hit    = cfg_q.pol ? (prev_q & ~sync_s) : (sync_s & ~prev_q);
    assign clr_hit     = wr_sel & wdata[BIT_CLR] & cfg_q.edge_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_sel) begin
            cfg_q.pol       <= wdata[BIT_POL];
            cfg_q.edge_mode <= wdata[BIT_MODE];
            cfg_q.en        <= wdata[BIT_EN];
            cfg_q.lvl       <= wdata[LVL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
            prev_q <= sync_s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_q.edge_mode) begin
            pend_q <= 1'b0;
        end else if (edge_hit) begin
            pend_q <= 1'b1;
        end else if (clr_hit) begin
            pend_q <= 1'b0;
        end
    end

    assign cfg_o    = cfg_q;
    assign active_o = cfg_q.edge_mode ? pend_q : (sync_s ^ cfg_q.pol);

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter  int N_SRC  = 16,
    localparam int CODE_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]            req,
    input  logic [N_SRC-1:0][LVL_W-1:0] lvl,
    output logic                        any_o,
    output logic [LVL_W-1:0]            lvl_o,
    output logic [CODE_W-1:0]           code_o
);

    always_comb begin
        any_o  = 1'b0;
        lvl_o  = '0;
        code_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && (lvl[i] != '0) && (lvl[i] >= lvl_o)) begin
                any_o  = 1'b1;
                lvl_o  = lvl[i];
                code_o = CODE_W'(i);
            end
        end
    end

endmodule

// File: rtl/intc_ack_fsm.sv
module intc_ack_fsm
    import intc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack,
    input  logic             grant_ok,
    input  logic [VEC_W-1:0] vec_next,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out
);

    ack_state_e       state_q;
    ack_state_e       state_d;
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:  if (iack) state_d = grant_ok ? ACK_GRANT : ACK_SPUR;
            ACK_GRANT: if (!iack) state_d = ACK_IDLE;
            ACK_SPUR:  if (!iack) state_d = ACK_IDLE;
            default:   state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (state_q == ACK_IDLE && state_d == ACK_GRANT) begin
            vec_q <= vec_next;
        end
    end

    assign vec_valid = (state_q == ACK_GRANT);
    assign vec_out   = vec_valid ? vec_q : '0;

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter  int N_SRC  = 16,
    parameter  int VEC_W  = 8,
    localparam int ADDR_W = $clog2(N_SRC + 2),
    localparam int CODE_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] cfg_raddr,
    output logic [7:0]        cfg_rdata,
    input  logic              iack,
    output logic [2:0]        cpu_ipl,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out
);

    localparam logic [ADDR_W-1:0] GEN_ADDR  = ADDR_W'(N_SRC);
    localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(N_SRC + 1);

    src_cfg_t [N_SRC-1:0]            cfg_w;
    logic     [N_SRC-1:0]            active_w;
    logic     [N_SRC-1:0]            req_w;
    logic     [N_SRC-1:0][LVL_W-1:0] lvl_w;
    logic                            req_any;
    logic     [LVL_W-1:0]            win_lvl;
    logic     [CODE_W-1:0]           win_code;
    logic                            master_q;
    logic     [VEC_W-1:0]            vbase_q;
    logic     [2:0]                  ipl_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        intc_src_cond #(.SYNC_STAGES(2)) u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (irq_in[g]),
            .wr_sel   (cfg_we && (cfg_addr == ADDR_W'(g))),
            .wdata    (cfg_wdata),
            .cfg_o    (cfg_w[g]),
            .active_o (active_w[g])
        );
        assign req_w[g] = active_w[g] & cfg_w[g].en;
        assign lvl_w[g] = cfg_w[g].lvl;
    end

    intc_arbiter #(.N_SRC(N_SRC)) u_arb (
        .req    (req_w),
        .lvl    (lvl_w),
        .any_o  (req_any),
        .lvl_o  (win_lvl),
        .code_o (win_code)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            vbase_q  <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == GEN_ADDR)  master_q <= cfg_wdata[0];
            if (cfg_addr == BASE_ADDR) vbase_q  <= VEC_W'(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipl_q <= '0;
        end else begin
            ipl_q <= master_q ? 3'(win_lvl) : 3'd0;
        end
    end

    intc_ack_fsm #(.VEC_W(VEC_W)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .iack      (iack),
        .grant_ok  (master_q && req_any),
        .vec_next  (vbase_q + VEC_W'(win_code)),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cfg_raddr == ADDR_W'(i)) begin
                cfg_rdata = {cfg_w[i].pol, cfg_w[i].edge_mode, active_w[i],
                             cfg_w[i].en, 1'b0, cfg_w[i].lvl};
            end
        end
        if (cfg_raddr == GEN_ADDR)  cfg_rdata = {7'd0, master_q};
        if (cfg_raddr == BASE_ADDR) cfg_rdata = 8'(vbase_q);
    end

    assign cpu_ipl = ipl_q;

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iack,
    input logic             master_en,
    input logic             req_any,
    input logic [2:0]       cpu_ipl,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_out
);

    AST_NO_IPL_WO_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (cpu_ipl == 3'd0)); // R8

    AST_NO_IPL_WO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_any |=> (cpu_ipl == 3'd0)); // R2

    AST_IPL_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && req_any) |=> (cpu_ipl != 3'd0)); // R7

    AST_VALID_NEEDS_IACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(iack)); // R10

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(vec_valid)) |-> $stable(vec_out)); // R10

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iack) |=> !vec_valid); // R10

endmodule

bind prio_vec_intc intc_checker #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iack      (iack),
    .master_en (master_q),
    .req_any   (req_any),
    .cpu_ipl   (cpu_ipl),
    .vec_valid (vec_valid),
    .vec_out   (vec_out)
);

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [4:0]  cfg_raddr = '0;
    logic [7:0]  cfg_rdata;
    logic        iack = 1'b0;
    logic [2:0]  cpu_ipl;
    logic        vec_valid;
    logic [7:0]  vec_out;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    bit [7:0] m_ctrl [N];
    bit       m_in   [N];
    bit       m_pend [N];
    bit       m_master = 1'b0;
    bit [7:0] m_base   = '0;

    always #4 clk = ~clk;

    prio_vec_intc #(.N_SRC(N), .VEC_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
        .cfg_rdata(cfg_rdata), .iack(iack), .cpu_ipl(cpu_ipl),
        .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    endtask

    function automatic bit m_active(int i);
        if (m_ctrl[i][6]) return m_pend[i];
        return m_in[i] ^ m_ctrl[i][7];
    endfunction

    function automatic int exp_lvl();
        int best = 0;
        for (int i = 0; i < N; i++)
            if (m_active(i) && m_ctrl[i][4] && int'(m_ctrl[i][2:0]) >= best && m_ctrl[i][2:0] != 0)
                best = m_ctrl[i][2:0];
        return best;
    endfunction

    function automatic int exp_code();
        int best = 0;
        int code = 0;
        for (int i = 0; i < N; i++)
            if (m_active(i) && m_ctrl[i][4] && int'(m_ctrl[i][2:0]) >= best && m_ctrl[i][2:0] != 0) begin
                best = m_ctrl[i][2:0];
                code = i;
            end
        return code;
    endfunction

    function automatic int exp_ipl();
        return m_master ? exp_lvl() : 0;
    endfunction

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(int addr, bit [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < N) begin
            if (m_ctrl[addr][6] && d[3]) m_pend[addr] = 1'b0;
            m_ctrl[addr] = d & 8'hD7;
            if (!m_ctrl[addr][6]) m_pend[addr] = 1'b0;
        end else if (addr == N) m_master = d[0];
        else if (addr == N + 1) m_base = d;
    endtask

    task automatic set_in(int i, bit v);
        @(negedge clk);
        if (v != m_in[i] && m_ctrl[i][6] && (v ^ m_ctrl[i][7])) m_pend[i] = 1'b1;
        m_in[i] = v;
        irq_in[i] = v;
    endtask

    task automatic rd_src(string req, int i);
        bit [7:0] e;
        cfg_raddr = 5'(i);
        #1;
        e = {m_ctrl[i][7:6], m_active(i), m_ctrl[i][4], 1'b0, m_ctrl[i][2:0]};
        chk(req, cfg_rdata, e);
    endtask

    task automatic do_ack(string req);
        bit ev;
        @(negedge clk);
        ev = m_master && (exp_lvl() != 0);
        iack = 1'b1;
        repeat (2) @(negedge clk);
        chk({req, " valid"}, vec_valid, ev);
        chk({req, " vector"}, vec_out, ev ? int'(8'(m_base + 8'(exp_code()))) : 0);
        iack = 1'b0;
        repeat (2) @(negedge clk);
        chk({req, " valid drop"}, vec_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < N; i++) begin m_ctrl[i] = 0; m_in[i] = 0; m_pend[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < N + 2; a++) begin
            cfg_raddr = 5'(a); #1;
            chk("R1 reset read", cfg_rdata, 0);
        end
        chk("R1 ipl", cpu_ipl, 0);
        chk("R1 valid", vec_valid, 0);

        // R11: ack with nothing pending
        wr(N, 8'h01);
        do_ack("R11 spurious");

        // R2: level zero and disabled sources never request
        wr(3, 8'h10);            // enabled, level 0, level mode high
        wr(4, 8'h05);            // disabled, level 5
        set_in(3, 1); set_in(4, 1);
        settle();
        chk("R2 no request", cpu_ipl, 0);
        rd_src("R3 active bit while disabled", 4);

        // R4: level mode, both polarities
        wr(5, 8'h93);            // low active, en, lvl 3
        settle();
        chk("R4 low-active asserts", cpu_ipl, 3);
        set_in(5, 1); settle();
        chk("R4 low-active releases", cpu_ipl, 0);
        wr(6, 8'h12); set_in(6, 1); settle();
        chk("R4 high-active asserts", cpu_ipl, 2);
        // R6: clear bit in level mode has no effect
        wr(6, 8'h1A); settle();
        chk("R6 level clear ignored", cpu_ipl, 2);
        rd_src("R3 readback level src", 6);
        set_in(6, 0); settle();

        // R5: edge mode rising and falling
        wr(7, 8'h54); settle();
        chk("R5 no edge on config", cpu_ipl, 0);
        set_in(7, 1); settle(); set_in(7, 0); settle();
        chk("R5 rising latched", cpu_ipl, 4);
        rd_src("R3 pending readback", 7);
        wr(7, 8'h5C); settle();
        chk("R6 edge clear", cpu_ipl, 0);
        wr(8, 8'hD6); set_in(8, 1); settle();
        chk("R5 falling not on rise", cpu_ipl, 0);
        set_in(8, 0); settle();
        chk("R5 falling latched", cpu_ipl, 6);

        // R9: tie broken by highest code; R12 wrap
        wr(9, 8'h16); set_in(9, 1); settle();
        wr(N + 1, 8'hF8);
        chk("R7 max level", cpu_ipl, 6);
        do_ack("R9 R12 tie and wrap");

        // R10: captured vector held while requests change
        @(negedge clk); iack = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 vector", vec_out, 8'h01);
        wr(15, 8'h17); set_in(15, 1); settle();
        chk("R10 held", vec_out, 8'h01);
        chk("R10 still valid", vec_valid, 1);
        iack = 1'b0; @(negedge clk); @(negedge clk);
        chk("R10 dropped", vec_valid, 0);
        chk("R7 new max", cpu_ipl, 7);

        // R8: master off
        wr(N, 8'h00); settle();
        chk("R8 ipl gated", cpu_ipl, 0);
        do_ack("R8 no vector");
        wr(N, 8'h01);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 10);
            int s  = int'($urandom % N);
            if (op < 4) wr(s, 8'($urandom));
            else if (op < 8) set_in(s, ~m_in[s]);
            else if (op == 8) begin
                if ($urandom % 4 == 0) wr(N, 8'($urandom % 2));
                else wr(N + 1, 8'($urandom));
            end else do_ack("R9 random ack");
            settle();
            chk("R7 random ipl", cpu_ipl, exp_ipl());
            rd_src("R3 random readback", s);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule